// File: doc/BRIEF.md
# Parallel Panel Command Bus Engine

This block lets a host talk to a display panel that carries its own controller, over a 16-bit parallel bus with a register-select line, two chip selects and separate active-low write and read strobes. The host stores a 32-bit command word whose control bits choose between an index (command) cycle and a data cycle. It then writes a start register, and the engine runs one bus cycle. The cycle has a setup phase, a strobe phase and a hold phase, and the length of each phase is programmable.

Reads work the same way. The host first writes a read-request word whose control bit selects index or data addressing. It then writes a separate read-start register. The panel's 16-bit answer is latched at the end of the read strobe, and the host fetches it from the low half of the read register. In both start registers, one bit carries the go request and another bit routes the cycle to the main panel or to the sub panel. A status bit stays high for as long as a cycle is on the bus.

The host port is a simple register port. Writes take effect on the clock edge where `hostWe` is high. Reads are combinational from `hostAddr`, with word addresses 0 = command word, 1 = read request/result, 2 = write start, 3 = read start, 4 = status, 5 = timing.

Top module: `panel_cmd_bus`

## Requirements
- R1: After reset both chip selects, the write strobe and the read strobe are high, the register-select line is low, the bus is not driven, status reads 0 and the read result reads 0.
- R2: Writing address 2 with bit 0 set launches a write cycle only if bit 28 of the stored command word is 1. If that bit is 0, no cycle starts.
- R3: During a write cycle the data pins carry bits 15:0 of the command word, and the bus is driven. The register-select line equals bit 24 of that word (1 = data, 0 = index) while a chip select is active, and is low otherwise.
- R4: Bit 1 of the start word selects the chip select: 0 = main panel, 1 = sub panel. At most one chip select is ever low.
- R5: Status bit 1 is 1 from the first clock after an accepted start until the cycle ends, and 0 when idle.
- R6: The timing register fields are setup [3:0] = S, strobe [7:4] = P and hold [11:8] = H. A cycle holds the chip select low for S+1 clocks with the strobe high, then P+1 clocks with the strobe low, then H+1 clocks with the strobe high, for S+P+H+3 busy clocks in all. The fields are taken at launch.
- R7: Bit 24 of the word written to address 1 sets the register-select level of a read. Writing address 3 with bit 0 set launches a read cycle that pulses the read strobe and leaves the bus undriven.
- R8: Read data is sampled from the panel bus on the clock edge where the read strobe returns high. It is returned in bits 15:0 of address 1, with bits 31:16 reading 0.
- R9: A start written while a cycle is in progress is ignored. Register writes made during a cycle do not change that cycle's data, register-select level or chip select.
- R10: A write to either start register with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWe | input | 1 | Host register write enable |
| hostAddr | input | 3 | Host register word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data (combinational) |
| panelDataOut | output | 16 | Bus data driven toward the panel |
| panelDataOe | output | 1 | High while the engine drives the bus |
| panelDataIn | input | 16 | Bus data returned by the panel |
| panelRs | output | 1 | Register select: 0 index, 1 data |
| panelCsMainN | output | 1 | Main panel chip select, active low |
| panelCsSubN | output | 1 | Sub panel chip select, active low |
| panelWrN | output | 1 | Write strobe, active low |
| panelRdN | output | 1 | Read strobe, active low |

## Verification
A start register write lands on one clock edge. The chip select and the busy flag appear in the cycle that follows that edge. The strobe then falls S+1 clocks later, rises after P+1 more clocks, and the chip select and busy flag clear H+1 clocks after that. The bench counts cycles from the launch edge and samples every pin, and the status bit, at the falling clock edge of each of those S+P+H+4 cycles. It compares each sample against the phase computed from the programmed timing. For reads, the panel data input carries junk before the strobe and a marker value during the strobe, and is flipped as soon as hold begins, so only a sample taken exactly at the strobe's rising edge returns the marker.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int HOST_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_WORD = 3'd0;
  localparam logic [ADDR_W-1:0] A_RREQ = 3'd1;
  localparam logic [ADDR_W-1:0] A_WGO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RGO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_TIME = 3'd5;

  localparam int BIT_CMDBUS = 28;
  localparam int BIT_RS     = 24;
  localparam int BIT_GO     = 0;
  localparam int BIT_SUB    = 1;
  localparam int BIT_BUSY   = 1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  typedef struct packed {
    logic launch;
    logic csOn;
    logic strobeOn;
    logic capture;
  } busCtl_t;
endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 goReq,
  input  logic [3*PHASE_W-1:0] timeCfg,
  output busCtl_t              ctl,
  output logic                 busy
);
  localparam int TW = 3*PHASE_W;

  phase_e            phase;
  logic [PHASE_W-1:0] cnt;
  logic [TW-1:0]     tLatched;
  logic              accept;
  logic              cntDone;

  // Per-phase lengths pulled from the latched timing word.
  logic [PHASE_W-1:0] phaseLen [3];
  generate
    for (genvar g = 0; g < 3; g++) begin : g_len
      assign phaseLen[g] = tLatched[g*PHASE_W +: PHASE_W];
    end
  endgenerate

  assign accept  = goReq && (phase == PH_IDLE);
  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      tLatched <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase    <= PH_SETUP;
          cnt      <= timeCfg[PHASE_W-1:0];
          tLatched <= timeCfg;
        end
        PH_SETUP: if (cntDone) begin
          phase <= PH_STROBE;
          cnt   <= phaseLen[1];
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cntDone) begin
          phase <= PH_HOLD;
          cnt   <= phaseLen[2];
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cntDone) begin
          phase <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.launch   = accept;
    ctl.csOn     = (phase != PH_IDLE);
    ctl.strobeOn = (phase == PH_STROBE);
    ctl.capture  = (phase == PH_STROBE) && cntDone;
  end
  assign busy = (phase != PH_IDLE);

  // R5: busy only rises after a go request was seen
  a_r5_busy_needs_go: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(goReq));
  // R6: the strobe phase is always entered from setup
  a_r6_strobe_after_setup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.strobeOn) |-> $past(phase == PH_SETUP));
  // R6: the cycle always ends from the hold phase
  a_r6_end_from_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(phase == PH_HOLD));
endmodule

// File: rtl/pbus_dpath.sv
module pbus_dpath
  import pbus_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWe,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [HOST_W-1:0]    hostWdata,
  output logic [HOST_W-1:0]    hostRdata,
  input  busCtl_t              ctl,
  input  logic                 busy,
  output logic                 goReq,
  output logic [3*PHASE_W-1:0] timeCfg,
  output logic [DATA_W-1:0]    panelDataOut,
  output logic                 panelDataOe,
  input  logic [DATA_W-1:0]    panelDataIn,
  output logic                 panelRs,
  output logic                 panelCsMainN,
  output logic                 panelCsSubN,
  output logic                 panelWrN,
  output logic                 panelRdN
);
  localparam int TW = 3*PHASE_W;

  logic [HOST_W-1:0] wordReg;
  logic              rreqRs;
  logic [TW-1:0]     timeReg;
  logic [DATA_W-1:0] rdCapt;
  logic [DATA_W-1:0] busData;
  logic              busRs, busSub, busRead;
  logic              wrGo, rdGo;

  assign wrGo  = hostWe && (hostAddr == A_WGO) && hostWdata[BIT_GO] && wordReg[BIT_CMDBUS];
  assign rdGo  = hostWe && (hostAddr == A_RGO) && hostWdata[BIT_GO];
  assign goReq = wrGo || rdGo;
  assign timeCfg = timeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      rreqRs  <= 1'b0;
      timeReg <= '0;
    end else if (hostWe) begin
      case (hostAddr)
        A_WORD:  wordReg <= hostWdata;
        A_RREQ:  rreqRs  <= hostWdata[BIT_RS];
        A_TIME:  timeReg <= hostWdata[TW-1:0];
        default: ;
      endcase
    end
  end

  // Copy of the cycle's attributes, frozen at launch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busData <= '0;
      busRs   <= 1'b0;
      busSub  <= 1'b0;
      busRead <= 1'b0;
    end else if (ctl.launch) begin
      busRead <= rdGo;
      busSub  <= hostWdata[BIT_SUB];
      busRs   <= rdGo ? rreqRs : wordReg[BIT_RS];
      busData <= wordReg[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        rdCapt <= '0;
    else if (ctl.capture && busRead)  rdCapt <= panelDataIn;
  end

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      A_WORD:  hostRdata = wordReg;
      A_RREQ:  hostRdata[DATA_W-1:0] = rdCapt;
      A_STAT:  hostRdata[BIT_BUSY] = busy;
      A_TIME:  hostRdata[TW-1:0] = timeReg;
      default: hostRdata = '0;
    endcase
  end

  assign panelCsMainN = !(ctl.csOn && !busSub);
  assign panelCsSubN  = !(ctl.csOn && busSub);
  assign panelRs      = ctl.csOn && busRs;
  assign panelWrN     = !(ctl.strobeOn && !busRead);
  assign panelRdN     = !(ctl.strobeOn && busRead);
  assign panelDataOut = busData;
  assign panelDataOe  = ctl.csOn && !busRead;

  // R4: never both panels selected
  a_r4_one_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!panelCsMainN, !panelCsSubN}));
  // R6: a strobe sits inside a chip select that was already active
  a_r6_strobe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!panelWrN || !panelRdN) |-> ((!panelCsMainN || !panelCsSubN) &&
                                  $past(!panelCsMainN || !panelCsSubN)));
  // R9: chip select choice holds for the whole cycle
  a_r9_cs_steady: assert property (@(posedge clk) disable iff (!rstN)
    ((!panelCsMainN || !panelCsSubN) && $past(!panelCsMainN || !panelCsSubN))
      |-> $stable({panelCsMainN, panelCsSubN, panelRs}));
  // R3: write data stays steady while the write strobe is low
  a_r3_data_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!panelWrN && $past(!panelWrN)) |-> $stable(panelDataOut));
  // R7: the bus is released during a read strobe
  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !panelRdN |-> !panelDataOe);
  // R7: the two strobes never overlap
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    panelWrN || panelRdN);
endmodule

// File: rtl/panel_cmd_bus.sv
module panel_cmd_bus
  import pbus_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [2:0]        hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic [DATA_W-1:0] panelDataOut,
  output logic              panelDataOe,
  input  logic [DATA_W-1:0] panelDataIn,
  output logic              panelRs,
  output logic              panelCsMainN,
  output logic              panelCsSubN,
  output logic              panelWrN,
  output logic              panelRdN
);
  busCtl_t              ctl;
  logic                 busy;
  logic                 goReq;
  logic [3*PHASE_W-1:0] timeCfg;

  pbus_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .goReq(goReq), .timeCfg(timeCfg),
    .ctl(ctl), .busy(busy)
  );

  pbus_dpath #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .ctl(ctl), .busy(busy),
    .goReq(goReq), .timeCfg(timeCfg), .panelDataOut(panelDataOut),
    .panelDataOe(panelDataOe), .panelDataIn(panelDataIn), .panelRs(panelRs),
    .panelCsMainN(panelCsMainN), .panelCsSubN(panelCsSubN),
    .panelWrN(panelWrN), .panelRdN(panelRdN)
  );
endmodule

// File: tb/panel_cmd_bus_bench.sv
module panel_cmd_bus_bench;
  localparam logic [2:0] A_WORD = 3'd0, A_RREQ = 3'd1, A_WGO = 3'd2,
                         A_RGO = 3'd3, A_STAT = 3'd4, A_TIME = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [2:0]  hostAddr = A_STAT;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic [15:0] panelDataOut;
  logic        panelDataOe;
  logic [15:0] panelDataIn = '0;
  logic        panelRs, panelCsMainN, panelCsSubN, panelWrN, panelRdN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  panel_cmd_bus u_panel_cmd_bus (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .panelDataOut(panelDataOut),
    .panelDataOe(panelDataOe), .panelDataIn(panelDataIn), .panelRs(panelRs),
    .panelCsMainN(panelCsMainN), .panelCsSubN(panelCsSubN),
    .panelWrN(panelWrN), .panelRdN(panelRdN)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0; hostAddr = A_STAT;
  endtask

  // Expected pin vector {csMainN, csSubN, wrN, rdN, rs, oe} for a phase.
  function automatic logic [5:0] expPins(input int ph, input bit sub, input bit rd, input bit rs);
    logic cs, stb;
    cs  = (ph != 0);
    stb = (ph == 2);
    return {!(cs && !sub), !(cs && sub), !(stb && !rd), !(stb && rd), cs && rs, cs && !rd};
  endfunction

  // ph: 0 idle, 1 setup, 2 strobe, 3 hold, at sample index i after the launch edge
  function automatic int phaseAt(input int i, input int s, input int p, input int h);
    if (i <= s) return 1;
    if (i <= s + p + 1) return 2;
    if (i <= s + p + h + 2) return 3;
    return 0;
  endfunction

  task automatic idleCheck(input string req);
    hostWe = 1'b0; hostAddr = A_STAT; #1;
    chk(req, {panelCsMainN, panelCsSubN, panelWrN, panelRdN, panelRs, panelDataOe}, 6'b111100);
    chk(req, 64'(hostRdata[1]), 64'd0);
  endtask

  // One full bus cycle with per-clock checks.
  task automatic runCycle(input bit rd, input logic [31:0] word, input bit sub,
                          input int s, input int p, input int h, input bit inject);
    int total;
    logic [15:0] inVal;
    bit rs;
    total = s + p + h + 3;
    inVal = 16'($urandom);
    rs = word[24];
    panelDataIn = ~inVal;
    hostWrite(A_TIME, {20'd0, 4'(h), 4'(p), 4'(s)});
    hostWrite(rd ? A_RREQ : A_WORD, word);
    hostWrite(rd ? A_RGO : A_WGO, {30'd0, sub, 1'b1});
    for (int i = 0; i <= total; i++) begin
      int ph;
      hostWe = 1'b0; hostAddr = A_STAT; #1;
      ph = phaseAt(i, s, p, h);
      chk("R6 pins", {panelCsMainN, panelCsSubN, panelWrN, panelRdN, panelRs, panelDataOe},
          expPins(ph, sub, rd, rs));
      chk("R5 busy", 64'(hostRdata[1]), 64'(ph != 0));
      if (!rd && ph != 0) chk("R3 data", 64'(panelDataOut), 64'(word[15:0]));
      if (i == s + 1) panelDataIn = inVal;
      if (i == s + p + 2) panelDataIn = ~inVal;
      if (inject && i == 1) begin
        hostWe = 1'b1; hostAddr = rd ? A_RREQ : A_WORD;
        hostWdata = ~word | 32'h1000_0000;
      end
      if (inject && i == 2) begin
        hostWe = 1'b1; hostAddr = rd ? A_RGO : A_WGO;
        hostWdata = {30'd0, ~sub, 1'b1};
      end
      if (i < total) @(negedge clk);
    end
    @(negedge clk);
    idleCheck(inject ? "R9 no late start" : "R5 stays idle");
    if (rd) begin
      hostAddr = A_RREQ; #1;
      chk("R8 read data", 64'(hostRdata), 64'({16'd0, inVal}));
      hostAddr = A_STAT;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1d5e);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    idleCheck("R1 reset");
    hostAddr = A_RREQ; #1;
    chk("R1 read result", 64'(hostRdata), 64'd0);

    // R2/R3 directed: data write, main panel, shortest timing
    runCycle(1'b0, 32'h1100_a5c3, 1'b0, 0, 0, 0, 1'b0);
    // R3 index write to sub panel (R4)
    runCycle(1'b0, 32'h1000_3c5a, 1'b1, 1, 2, 1, 1'b0);
    // R6 longest phases
    runCycle(1'b0, 32'h1100_ffff, 1'b0, 15, 15, 15, 1'b0);
    // R7/R8 read data and index
    runCycle(1'b1, 32'h0100_0000, 1'b1, 2, 0, 1, 1'b0);
    runCycle(1'b1, 32'h0000_0000, 1'b0, 0, 3, 0, 1'b0);
    // R9 start and word writes during a cycle
    runCycle(1'b0, 32'h1100_1234, 1'b0, 1, 1, 1, 1'b1);
    runCycle(1'b1, 32'h0100_0000, 1'b1, 1, 1, 1, 1'b1);

    // R2 command-bus bit clear: no cycle
    hostWrite(A_WORD, 32'h0100_7777);
    hostWrite(A_WGO, 32'h1);
    repeat (2) @(negedge clk);
    idleCheck("R2 no cycle without bit 28");
    // R10 go bit clear on both start registers
    hostWrite(A_WORD, 32'h1100_7777);
    hostWrite(A_WGO, 32'h2);
    @(negedge clk);
    idleCheck("R10 write start bit0 clear");
    hostWrite(A_RGO, 32'h2);
    @(negedge clk);
    idleCheck("R10 read start bit0 clear");

    // Random mix
    for (int k = 0; k < 40; k++) begin
      int s, p, h;
      bit big;
      big = ($urandom % 4) == 0;
      s = big ? int'($urandom % 16) : int'($urandom % 3);
      p = big ? int'($urandom % 16) : int'($urandom % 3);
      h = big ? int'($urandom % 16) : int'($urandom % 3);
      runCycle(1'($urandom), ($urandom & 32'h0100_ffff) | 32'h1000_0000,
               1'($urandom), s, p, h, ($urandom % 5) == 0);
    end

    done = 1;
    finishRun();
  end
endmodule